// File: doc/BRIEF.md
# USB OUT Endpoint Control and Receive-Packet Tracker

This block keeps the control/status register and the packet bookkeeping of one USB function OUT endpoint. The endpoint's receive FIFO can hold two packets. The serial interface engine reports each packet as a start pulse, a strobe per data byte, and an end pulse. An error flag travels with the end pulse and marks a CRC or bit-stuffing fault. One cycle after the end pulse, the block returns the handshake for that packet. It also decides whether the packet is kept, and it updates the status flags.

On the CPU side there is one 8-bit control/status register and one maximum-packet-size register. A strobe reports each byte the CPU unloads from the FIFO. Status flags are sticky: the CPU clears them by writing 0. A flush command discards the older held packet. An optional automatic mode releases the head packet after the CPU has unloaded exactly the packet limit in bytes. The FIFO storage itself, token decoding and CRC checking are outside the block.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: After reset, `csr_rdata` reads 0x00, `maxp_rdata` reads the `RESET_MAXP` parameter value, and `hs_valid` is low.
- R2: The sticky flags are overrun (bit 1), forced stall (bit 4) and data error (bit 5). A CSR write with 0 in one of these bits clears that flag. A write with 1 in that bit leaves the flag unchanged.
- R3: Send-stall (bit 2), isochronous mode (bit 3) and auto-release (bit 7) read back as written. The flush bit (bit 6) always reads 0.
- R4: Some packets end without error, with the endpoint not stalled, a length at most the packet limit, and a free slot. Such a packet is stored and sets packet-ready (bit 0). In non-isochronous mode, `hs_valid` is high in the cycle after the end pulse, with `hs_code` 01 (ACK). NAK is coded 10 and STALL 11.
- R5: A packet longer than the packet limit sets the forced-stall flag and is not stored. In non-isochronous mode it is answered with STALL.
- R6: While send-stall or forced-stall is set, every error-free packet is answered with STALL and is not stored.
- R7: A packet that arrives while two packets are already held sets the overrun flag and is dropped. In non-isochronous mode it is answered with NAK.
- R8: A packet that ends with the error flag is never stored. In non-isochronous mode it gets no handshake and no flag changes. In isochronous mode it sets the data-error flag.
- R9: In isochronous mode no handshake is ever returned.
- R10: Each CSR write with 0 in bit 0 or 1 in bit 6 releases the older held packet, at most one per write. Packet-ready stays 1 while another packet is still held.
- R11: A flush written while a packet is being received is ignored. Here, receiving means from the cycle after the start pulse to the end pulse.
- R12: With auto-release set, the head packet is released on the unload strobe that completes exactly the packet limit in bytes since that packet became the head. Counting restarts for the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | 8 | CSR write data |
| csr_rdata | output | 8 | CSR read value |
| maxp_we | input | 1 | Packet-limit register write strobe |
| maxp_wdata | input | MAXP_W | Packet-limit write data |
| maxp_rdata | output | MAXP_W | Packet-limit register value |
| fifo_rd | input | 1 | One byte unloaded from the FIFO by the CPU |
| rx_start | input | 1 | Start of an OUT data packet |
| rx_byte | input | 1 | One received data byte |
| rx_end | input | 1 | End of the packet |
| rx_err | input | 1 | With `rx_end`: CRC or bit-stuffing error |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 01 ACK, 10 NAK, 11 STALL, 00 none |

## Verification
The bench builds the block with `MAXP_W` = 4 and `RESET_MAXP` = 8. The 5-bit saturating length counter and the unload counter are small, so the bench can sweep every packet limit from 0 to 6. Each limit is tried against every length up to two past it, and the ACK/STALL boundary is checked on both sides. Auto-release is swept over limits 1 to 5 with two packets queued. This shows that the release lands exactly on the limit-th strobe and that counting restarts for the second packet.

// File: rtl/usb_oep_pkg.sv
package usb_oep_pkg;

  localparam int B_RDY   = 0;
  localparam int B_OVR   = 1;
  localparam int B_STALL = 2;
  localparam int B_ISO   = 3;
  localparam int B_FST   = 4;
  localparam int B_DERR  = 5;
  localparam int B_FLUSH = 6;
  localparam int B_AUTO  = 7;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  typedef enum logic [2:0] {
    V_COMMIT,
    V_DROP_ERR,
    V_STALL,
    V_OVERSIZE,
    V_OVERRUN
  } verdict_e;

  // Precedence: line error, endpoint stalled, too long, no free slot.
  function automatic verdict_e rx_verdict(input logic err, input logic stalled,
                                          input logic too_long, input logic full);
    if (err)           return V_DROP_ERR;
    else if (stalled)  return V_STALL;
    else if (too_long) return V_OVERSIZE;
    else if (full)     return V_OVERRUN;
    else               return V_COMMIT;
  endfunction

  function automatic hs_e verdict_hs(input verdict_e v);
    case (v)
      V_COMMIT:   return HS_ACK;
      V_OVERRUN:  return HS_NAK;
      V_STALL,
      V_OVERSIZE: return HS_STALL;
      default:    return HS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/usb_oep_rx_len.sv
module usb_oep_rx_len #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_start,
  input  logic             rx_byte,
  input  logic             rx_end,
  output logic             busy,
  output logic             pkt_done,
  output logic [LEN_W-1:0] len_total
);

  logic [LEN_W-1:0] len_q;

  function automatic logic [LEN_W-1:0] sat_inc(input logic [LEN_W-1:0] v, input logic en);
    if (en && (v != '1)) return v + 1'b1;
    return v;
  endfunction

  assign len_total = sat_inc(len_q, rx_byte);
  assign pkt_done  = busy && rx_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      len_q <= '0;
    end else if (rx_start) begin
      busy  <= 1'b1;
      len_q <= '0;
    end else if (busy) begin
      len_q <= len_total;
      if (rx_end) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/usb_oep_unload.sv
module usb_oep_unload #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_rd,
  input  logic             have_pkt,
  input  logic             auto_en,
  input  logic [LEN_W-1:0] limit,
  input  logic             head_pop,
  output logic             auto_pop
);

  logic [LEN_W-1:0] rd_q;
  logic [LEN_W:0]   rd_next;

  assign rd_next  = {1'b0, rd_q} + 1'b1;
  assign auto_pop = auto_en && fifo_rd && have_pkt && (rd_next == {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   rd_q <= '0;
    else if (head_pop)                            rd_q <= '0;
    else if (fifo_rd && have_pkt && rd_q != '1)   rd_q <= rd_next[LEN_W-1:0];
  end

endmodule

// File: rtl/usb_oep_sticky.sv
module usb_oep_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl
  import usb_oep_pkg::*;
#(
  parameter int MAXP_W     = 8,
  parameter int RESET_MAXP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  input  logic              maxp_we,
  input  logic [MAXP_W-1:0] maxp_wdata,
  output logic [MAXP_W-1:0] maxp_rdata,
  input  logic              fifo_rd,
  input  logic              rx_start,
  input  logic              rx_byte,
  input  logic              rx_end,
  input  logic              rx_err,
  output logic              hs_valid,
  output logic [1:0]        hs_code
);

  localparam int LEN_W  = MAXP_W + 1;
  localparam int SLOTS  = 2;
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int NFLAG  = 3;
  localparam int FIDX_OVR = 0, FIDX_FST = 1, FIDX_DERR = 2;

  logic [MAXP_W-1:0] maxp_q;
  logic              send_stall, iso_q, auto_q;
  logic [CNT_W-1:0]  pkt_cnt;
  logic              rx_busy, pkt_done;
  logic [LEN_W-1:0]  len_total;
  logic              stalled, too_long, full;
  verdict_e          verdict;
  logic              commit, cpu_pop, auto_pop, head_pop, have_pkt;
  logic [NFLAG-1:0]  flag_set, flag_clr, flag_q;
  hs_e               hs_q;

  usb_oep_rx_len #(.LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_byte(rx_byte),
    .rx_end(rx_end), .busy(rx_busy), .pkt_done(pkt_done), .len_total(len_total)
  );

  assign have_pkt = (pkt_cnt != '0);
  assign full     = (pkt_cnt == CNT_W'(SLOTS));
  assign stalled  = send_stall | flag_q[FIDX_FST];
  assign too_long = (len_total > {1'b0, maxp_q});
  assign verdict  = rx_verdict(rx_err, stalled, too_long, full);
  assign commit   = pkt_done && (verdict == V_COMMIT);

  assign cpu_pop  = csr_we && have_pkt &&
                    (!csr_wdata[B_RDY] || (csr_wdata[B_FLUSH] && !rx_busy));
  assign head_pop = cpu_pop || auto_pop;

  usb_oep_unload #(.LEN_W(LEN_W)) u_unl (
    .clk(clk), .rst_n(rst_n), .fifo_rd(fifo_rd), .have_pkt(have_pkt),
    .auto_en(auto_q), .limit({1'b0, maxp_q}), .head_pop(head_pop), .auto_pop(auto_pop)
  );

  assign flag_set[FIDX_OVR]  = pkt_done && (verdict == V_OVERRUN);
  assign flag_set[FIDX_FST]  = pkt_done && (verdict == V_OVERSIZE);
  assign flag_set[FIDX_DERR] = pkt_done && (verdict == V_DROP_ERR) && iso_q;
  assign flag_clr[FIDX_OVR]  = csr_we && !csr_wdata[B_OVR];
  assign flag_clr[FIDX_FST]  = csr_we && !csr_wdata[B_FST];
  assign flag_clr[FIDX_DERR] = csr_we && !csr_wdata[B_DERR];

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    usb_oep_sticky u_flag (
      .clk(clk), .rst_n(rst_n), .set(flag_set[g]), .clr(flag_clr[g]), .q(flag_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maxp_q     <= MAXP_W'(RESET_MAXP);
      send_stall <= 1'b0;
      iso_q      <= 1'b0;
      auto_q     <= 1'b0;
    end else begin
      if (maxp_we) maxp_q <= maxp_wdata;
      if (csr_we) begin
        send_stall <= csr_wdata[B_STALL];
        iso_q      <= csr_wdata[B_ISO];
        auto_q     <= csr_wdata[B_AUTO];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pkt_cnt <= '0;
    else        pkt_cnt <= pkt_cnt + CNT_W'(commit) - CNT_W'(head_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          hs_q <= HS_NONE;
    else if (pkt_done && !iso_q && verdict != V_DROP_ERR) hs_q <= verdict_hs(verdict);
    else                                                  hs_q <= HS_NONE;
  end

  assign hs_valid   = (hs_q != HS_NONE);
  assign hs_code    = hs_q;
  assign maxp_rdata = maxp_q;

  always_comb begin
    csr_rdata          = '0;
    csr_rdata[B_RDY]   = have_pkt;
    csr_rdata[B_OVR]   = flag_q[FIDX_OVR];
    csr_rdata[B_STALL] = send_stall;
    csr_rdata[B_ISO]   = iso_q;
    csr_rdata[B_FST]   = flag_q[FIDX_FST];
    csr_rdata[B_DERR]  = flag_q[FIDX_DERR];
    csr_rdata[B_AUTO]  = auto_q;
  end

endmodule

// File: rtl/usb_out_ep_ctrl_chk.sv
module usb_out_ep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pkt_done,
  input logic       rx_err,
  input logic       stalled,
  input logic       too_long,
  input logic       iso_q,
  input logic [1:0] pkt_cnt,
  input logic       csr_we,
  input logic [7:0] csr_wdata,
  input logic [7:0] csr_rdata,
  input logic       hs_valid,
  input logic [1:0] hs_code
);

  a_r6_stall_answer: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && !rx_err && stalled && !iso_q |=> hs_valid && hs_code == 2'b11);

  a_r9_iso_silent: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && iso_q |=> !hs_valid);

  a_r8_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && rx_err |=> !hs_valid);

  a_r2_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[1] && csr_we && csr_wdata[1] |=> csr_rdata[1]);

  a_r2_fst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[4] && csr_we && csr_wdata[4] |=> csr_rdata[4]);

  a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && !rx_err && !stalled && !too_long && pkt_cnt == 2'd2 |=> csr_rdata[1]);

  a_r5_oversize_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && !rx_err && !stalled && too_long |=> csr_rdata[4]);

  a_r4_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_cnt != 2'd3);

  a_r3_flush_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we && csr_wdata[6] |=> !csr_rdata[6]);

endmodule

bind usb_out_ep_ctrl usb_out_ep_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .rx_err(rx_err),
  .stalled(stalled), .too_long(too_long), .iso_q(iso_q), .pkt_cnt(pkt_cnt),
  .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
  .hs_valid(hs_valid), .hs_code(hs_code)
);

// File: tb/tb_usb_out_ep_ctrl.sv
module tb_usb_out_ep_ctrl;

  localparam int MW = 4;
  localparam int RM = 8;

  localparam logic [7:0] W_KEEP = 8'h33;  // no clear, no pop, controls off
  localparam logic [7:0] W_POP  = 8'h32;
  localparam logic [7:0] W_FLSH = 8'h73;
  localparam logic [7:0] W_COVR = 8'h31;
  localparam logic [7:0] W_CFST = 8'h23;
  localparam logic [7:0] W_CDER = 8'h13;
  localparam logic [7:0] W_ISO  = 8'h3B;
  localparam logic [7:0] W_STL  = 8'h37;
  localparam logic [7:0] W_AUTO = 8'hB3;

  logic          clk = 0, rst_n = 0;
  logic          csr_we = 0, maxp_we = 0, fifo_rd = 0;
  logic [7:0]    csr_wdata = 0, csr_rdata;
  logic [MW-1:0] maxp_wdata = 0, maxp_rdata;
  logic          rx_start = 0, rx_byte = 0, rx_end = 0, rx_err = 0;
  logic          hs_valid;
  logic [1:0]    hs_code;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usb_out_ep_ctrl #(.MAXP_W(MW), .RESET_MAXP(RM)) dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .maxp_we(maxp_we), .maxp_wdata(maxp_wdata),
    .maxp_rdata(maxp_rdata), .fifo_rd(fifo_rd), .rx_start(rx_start),
    .rx_byte(rx_byte), .rx_end(rx_end), .rx_err(rx_err),
    .hs_valid(hs_valid), .hs_code(hs_code)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [7:0] d);
    csr_we = 1; csr_wdata = d; cyc(); csr_we = 0;
  endtask

  task automatic set_maxp(input int m);
    maxp_we = 1; maxp_wdata = MW'(m); cyc(); maxp_we = 0;
  endtask

  task automatic unload();
    fifo_rd = 1; cyc(); fifo_rd = 0;
  endtask

  task automatic send(input int len, input bit err, output bit v, output logic [1:0] c);
    rx_start = 1; cyc(); rx_start = 0;
    for (int i = 0; i < len; i++) begin rx_byte = 1; cyc(); end
    rx_byte = 0; rx_end = 1; rx_err = err; cyc();
    v = hs_valid; c = hs_code;
    rx_end = 0; rx_err = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit v; logic [1:0] c; logic [7:0] snap;
    #25; rst_n = 1; cyc();

    // R1: reset state
    chk(csr_rdata == 8'h00, "R1 csr", csr_rdata, 0);
    chk(maxp_rdata == MW'(RM), "R1 maxp", maxp_rdata, RM);
    chk(!hs_valid, "R1 hs", hs_valid, 0);

    // R3: control bits read back, flush reads 0
    csr_wr(8'hFF);
    chk(csr_rdata == 8'h8C, "R3 readback", csr_rdata, 8'h8C);
    csr_wr(W_KEEP);
    chk(csr_rdata == 8'h00, "R3 cleared", csr_rdata, 0);

    // R4/R5: sweep limit against length across the boundary
    for (int m = 0; m <= 6; m++) begin
      set_maxp(m);
      for (int len = 0; len <= m + 2; len++) begin
        send(len, 0, v, c);
        if (len <= m) begin
          chk(v && c == 2'b01, "R4 ack", c, 1);
          chk(csr_rdata[0] == 1'b1, "R4 ready", csr_rdata, 1);
          csr_wr(W_POP);
          chk(csr_rdata[0] == 1'b0, "R10 pop", csr_rdata, 0);
        end else begin
          chk(v && c == 2'b11, "R5 stall", c, 3);
          chk(csr_rdata[4] && !csr_rdata[0], "R5 flag", csr_rdata, 8'h10);
          csr_wr(W_KEEP);
          chk(csr_rdata[4] == 1'b1, "R2 write1 fst", csr_rdata, 8'h10);
          csr_wr(W_CFST);
          chk(csr_rdata[4] == 1'b0, "R2 clear fst", csr_rdata, 0);
        end
      end
    end

    // R6: CPU stall
    set_maxp(8);
    csr_wr(W_STL);
    send(1, 0, v, c);
    chk(v && c == 2'b11, "R6 stall hs", c, 3);
    chk(csr_rdata == 8'h04, "R6 not stored", csr_rdata, 8'h04);
    csr_wr(W_KEEP);

    // R7 + R2: overrun on third packet
    send(2, 0, v, c); send(3, 0, v, c);
    send(1, 0, v, c);
    chk(v && c == 2'b10, "R7 nak", c, 2);
    chk(csr_rdata == 8'h03, "R7 flags", csr_rdata, 8'h03);
    csr_wr(W_KEEP);
    chk(csr_rdata[1] == 1'b1, "R2 write1 ovr", csr_rdata, 8'h03);
    csr_wr(W_COVR);
    chk(csr_rdata == 8'h01, "R2 clear ovr", csr_rdata, 8'h01);

    // R10: flush drops older packet, one per write
    csr_wr(W_FLSH);
    chk(csr_rdata[0] == 1'b1, "R10 second held", csr_rdata, 1);
    csr_wr(W_FLSH);
    chk(csr_rdata[0] == 1'b0, "R10 empty", csr_rdata, 0);
    csr_wr(W_FLSH);
    chk(csr_rdata == 8'h00, "R10 flush empty", csr_rdata, 0);

    // R11: flush during reception ignored
    send(1, 0, v, c);
    rx_start = 1; cyc(); rx_start = 0;
    rx_byte = 1; cyc(); rx_byte = 0;
    csr_wr(W_FLSH);
    rx_end = 1; cyc(); rx_end = 0;
    chk(hs_valid && hs_code == 2'b01, "R11 ack", hs_code, 1);
    csr_wr(W_POP);
    chk(csr_rdata[0] == 1'b1, "R11 two held", csr_rdata, 1);
    csr_wr(W_POP);
    chk(csr_rdata[0] == 1'b0, "R11 drained", csr_rdata, 0);

    // R8: errored packet, non-iso then iso
    snap = csr_rdata;
    send(2, 1, v, c);
    chk(!v, "R8 no hs", hs_code, 0);
    chk(csr_rdata == snap, "R8 no change", csr_rdata, snap);
    csr_wr(W_ISO);
    send(2, 1, v, c);
    chk(!v, "R9 iso err no hs", hs_code, 0);
    chk(csr_rdata == 8'h28, "R8 data err", csr_rdata, 8'h28);
    csr_wr(W_CDER | 8'h08);
    chk(csr_rdata == 8'h08, "R2 clear derr", csr_rdata, 8'h08);

    // R9: iso good packet stored, no handshake
    send(3, 0, v, c);
    chk(!v && csr_rdata[0], "R9 iso good", {v, csr_rdata[0]}, 1);
    csr_wr(W_POP);

    // R12: auto-release sweep
    for (int m = 1; m <= 5; m++) begin
      set_maxp(m);
      csr_wr(W_AUTO);
      send(m, 0, v, c); send(m, 0, v, c);
      for (int k = 0; k < m - 1; k++) unload();
      chk(csr_rdata[0] == 1'b1, "R12 not early", csr_rdata, 1);
      unload();
      for (int k = 0; k < m - 1; k++) unload();
      chk(csr_rdata[0] == 1'b1, "R12 restart", csr_rdata, 1);
      unload();
      chk(csr_rdata[0] == 1'b0, "R12 released", csr_rdata, 0);
      csr_wr(W_KEEP);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule